// File: doc/BRIEF.md
# DRAM Low-Power State Manager

This block sits between the command scheduler of a DRAM controller and the memory command bus. It decides when the memory device enters and leaves power down, self-refresh and deep power down. It drives the clock-enable (CKE) pin and the gate on the memory clock. It also issues abstract commands on the command bus: precharge-all, and entry and exit for each low-power state.

Two idle timers run side by side. A cycle counts as idle when the command queue is empty and no new request strobe is present. Each timer has its own programmable threshold: a short one for power down and a longer one for self-refresh. One configuration bit chooses between two power-down styles. In the first, CKE drops at once and the power-down flavour follows whatever rows are open. In the second, all banks are closed with a precharge-all before CKE drops. Any sign of traffic wakes the device. Software can also force a low-power state directly. After self-refresh or deep power down, the block holds the scheduler off for a programmable number of cycles.

Top module: `dram_lowpower_mgr`

## Requirements
- R1: With power-down threshold T nonzero and the style bit low, after T idle cycles plus one more idle cycle the block presents power-down entry (code 2) for one cycle and drives cke low. Any non-idle cycle (queue not empty or request strobe high) restarts the count from zero.
- R2: With the style bit low, pd_active is high during power down exactly when at least one bit of bank_open was set in the cycle the entry was decided.
- R3: With the style bit high, automatic power down first presents precharge-all (code 1) for one cycle. It then presents power-down entry on the next cycle, and pd_active stays low.
- R4: In power down, the first non-idle cycle causes power-down exit (code 3) with cke high on the next cycle, and busy drops in that same cycle.
- R5: When the self-refresh threshold S (nonzero) is reached in the normal state, the block presents precharge-all and then self-refresh entry (code 4) on consecutive cycles, with cke low from the entry cycle onward.
- R6: If S is reached while the device is in power down, the block presents power-down exit, precharge-all and self-refresh entry on three consecutive cycles. Cke is high only for the exit and precharge cycles.
- R7: In self-refresh, the first non-idle cycle causes self-refresh exit (code 5) with cke high on the next cycle. Busy stays high in that cycle and for xwait_cycles further cycles.
- R8: With clkstop_en high, clk_en is low throughout self-refresh and deep power down. When mem_is_lp is high it is also low during power down entered with no open row. In every other case clk_en is high.
- R9: A direct command is accepted only in the normal state. Codes: 1 = power down without precharge, 2 = precharge-all then self-refresh, 3 = deep power-down entry (code 6) with cke low. In any other state it has no effect on the outputs.
- R10: A threshold of zero disables that automatic entry. Endless idle then produces no command.
- R11: After reset, cke and clk_en are high, busy and pd_active are low, and no command is presented (cmd_valid low, code 0).
- R12: When both thresholds are reached in the same normal-state cycle, self-refresh entry takes precedence over power down.
- R13: In deep power down, the first non-idle cycle causes deep power-down exit (code 7) with cke high. The same hold-off as in R7 follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| q_empty | input | 1 | Command queue is empty |
| new_req | input | 1 | Strobe: a new bus transaction arrived |
| bank_open | input | NB | One bit per bank, set while a row is open |
| pd_thresh | input | CW | Idle cycles before power down, 0 disables |
| sr_thresh | input | CW | Idle cycles before self-refresh, 0 disables |
| force_pre | input | 1 | 1: close all banks before power down |
| clkstop_en | input | 1 | Allow gating of the memory clock |
| mem_is_lp | input | 1 | 1: low-power DDR type, 0: standard DDR2 |
| xwait_cycles | input | WW | Extra hold-off cycles after self-refresh or deep power-down exit |
| dcmd_valid | input | 1 | Direct command request |
| dcmd_code | input | 2 | Direct command selector |
| cke | output | 1 | Memory clock-enable pin |
| clk_en | output | 1 | Memory clock gate enable |
| cmd_valid | output | 1 | A command is presented this cycle |
| cmd_code | output | 3 | Command code |
| pd_active | output | 1 | Current power down keeps a row open |
| busy | output | 1 | Scheduler must not issue commands |

## Verification
The assertions assume that the thresholds and the style bit change only while the queue is busy, so that no idle count spans two settings. The stimulus applies every configuration change while q_empty is low. The assertions also assume that direct commands arrive as single-cycle pulses, and the stimulus drives them that way. The bench model counts idle cycles with unbounded integers instead of saturating counters. That is equivalent only under the stable-threshold assumption, which the stimulus keeps.

// File: rtl/dlp_pkg.sv
package dlp_pkg;

  typedef enum logic [2:0] {
    CMD_NOP  = 3'd0,
    CMD_PREA = 3'd1,
    CMD_PDE  = 3'd2,
    CMD_PDX  = 3'd3,
    CMD_SRE  = 3'd4,
    CMD_SRX  = 3'd5,
    CMD_DPDE = 3'd6,
    CMD_DPDX = 3'd7
  } dlp_cmd_e;

  typedef enum logic [2:0] {
    ST_RUN,
    ST_PRE_PD,
    ST_PD,
    ST_PDX_SR,
    ST_PRE_SR,
    ST_SR,
    ST_DPD,
    ST_XWAIT
  } dlp_st_e;

  localparam logic [1:0] DC_PD  = 2'd1;
  localparam logic [1:0] DC_SR  = 2'd2;
  localparam logic [1:0] DC_DPD = 2'd3;

  // clock may be gated: always in self-refresh / deep power down,
  // and in precharge power down only for low-power memory types
  function automatic logic f_clock_stop(input logic en, input logic lp,
                                        input dlp_st_e st, input logic act);
    logic deep;
    deep = (st == ST_SR) || (st == ST_DPD);
    return en && (deep || (lp && (st == ST_PD) && !act));
  endfunction

endpackage

// File: rtl/dlp_idle_timer.sv
module dlp_idle_timer #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic [CW-1:0] thr,
  output logic          hit
);

  logic [CW-1:0] cnt;

  function automatic logic [CW-1:0] next_cnt(input logic c,
                                             input logic [CW-1:0] v,
                                             input logic [CW-1:0] t);
    if (c) return '0;
    if (t == '0 || v >= t) return v;
    return v + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= next_cnt(clr, cnt, thr);
  end

  assign hit = (thr != '0) && (cnt >= thr);

  // R1: any non-idle cycle restarts the count
  a_r1_clear_restarts: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt == '0));

  // R10: a disabled timer never counts
  a_r10_zero_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (thr == '0) && $past(thr == '0) && !clr |-> $stable(cnt));

endmodule

// File: rtl/dlp_fsm.sv
module dlp_fsm
  import dlp_pkg::*;
#(
  parameter int WW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wake,
  input  logic          pd_hit,
  input  logic          sr_hit,
  input  logic          force_pre,
  input  logic          row_open,
  input  logic [WW-1:0] xwait,
  input  logic          dcmd_valid,
  input  logic [1:0]    dcmd_code,
  output logic          cke,
  output dlp_cmd_e      cmd,
  output dlp_st_e       st,
  output logic          pd_act
);

  logic [WW-1:0] wcnt;
  logic          dcmd_take;

  assign dcmd_take = dcmd_valid && (dcmd_code != 2'd0) && (st == ST_RUN);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= ST_RUN;
      cke    <= 1'b1;
      cmd    <= CMD_NOP;
      pd_act <= 1'b0;
      wcnt   <= '0;
    end else begin
      cmd <= CMD_NOP;
      unique case (st)
        ST_RUN: begin
          if (dcmd_take) begin
            if (dcmd_code == DC_PD) begin
              cmd <= CMD_PDE; cke <= 1'b0; pd_act <= row_open; st <= ST_PD;
            end else if (dcmd_code == DC_SR) begin
              cmd <= CMD_PREA; st <= ST_PRE_SR;
            end else begin
              cmd <= CMD_DPDE; cke <= 1'b0; st <= ST_DPD;
            end
          end else if (!wake && sr_hit) begin
            cmd <= CMD_PREA; st <= ST_PRE_SR;
          end else if (!wake && pd_hit) begin
            if (force_pre) begin
              cmd <= CMD_PREA; st <= ST_PRE_PD;
            end else begin
              cmd <= CMD_PDE; cke <= 1'b0; pd_act <= row_open; st <= ST_PD;
            end
          end
        end
        ST_PRE_PD: begin
          cmd <= CMD_PDE; cke <= 1'b0; pd_act <= 1'b0; st <= ST_PD;
        end
        ST_PD: begin
          if (wake) begin
            cmd <= CMD_PDX; cke <= 1'b1; pd_act <= 1'b0; st <= ST_RUN;
          end else if (sr_hit) begin
            cmd <= CMD_PDX; cke <= 1'b1; pd_act <= 1'b0; st <= ST_PDX_SR;
          end
        end
        ST_PDX_SR: begin
          cmd <= CMD_PREA; st <= ST_PRE_SR;
        end
        ST_PRE_SR: begin
          cmd <= CMD_SRE; cke <= 1'b0; st <= ST_SR;
        end
        ST_SR: begin
          if (wake) begin
            cmd <= CMD_SRX; cke <= 1'b1; wcnt <= xwait; st <= ST_XWAIT;
          end
        end
        ST_DPD: begin
          if (wake) begin
            cmd <= CMD_DPDX; cke <= 1'b1; wcnt <= xwait; st <= ST_XWAIT;
          end
        end
        ST_XWAIT: begin
          if (wcnt == '0) st <= ST_RUN;
          else            wcnt <= wcnt - 1'b1;
        end
        default: st <= ST_RUN;
      endcase
    end
  end

  // R5: self-refresh entry always follows a precharge-all
  a_r5_sre_after_prea: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == CMD_SRE) |-> ($past(cmd) == CMD_PREA));

  // R1: cke is low only in a low-power state
  a_r1_cke_low_states: assert property (@(posedge clk) disable iff (!rst_n)
    !cke |-> (st == ST_PD || st == ST_SR || st == ST_DPD));

  // R4: traffic in power down leads to an exit on the next cycle
  a_r4_wake_exit: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_PD && wake) |=> (cmd == CMD_PDX && cke));

  // R7: no command during the exit hold-off after its first cycle
  a_r7_holdoff_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_XWAIT && $past(st) == ST_XWAIT) |-> (cmd == CMD_NOP));

  // R9: direct commands outside the normal state change nothing
  a_r9_dcmd_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (dcmd_valid && st == ST_SR && !wake) |=> (st == ST_SR && !cke));

endmodule

// File: rtl/dram_lowpower_mgr.sv
module dram_lowpower_mgr
  import dlp_pkg::*;
#(
  parameter int NB = 8,
  parameter int CW = 16,
  parameter int WW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          q_empty,
  input  logic          new_req,
  input  logic [NB-1:0] bank_open,
  input  logic [CW-1:0] pd_thresh,
  input  logic [CW-1:0] sr_thresh,
  input  logic          force_pre,
  input  logic          clkstop_en,
  input  logic          mem_is_lp,
  input  logic [WW-1:0] xwait_cycles,
  input  logic          dcmd_valid,
  input  logic [1:0]    dcmd_code,
  output logic          cke,
  output logic          clk_en,
  output logic          cmd_valid,
  output logic [2:0]    cmd_code,
  output logic          pd_active,
  output logic          busy
);

  localparam int NTIMER = 2;

  logic          wake;
  logic [CW-1:0] thr_arr [NTIMER];
  logic [NTIMER-1:0] hit_vec;
  dlp_cmd_e      cmd;
  dlp_st_e       st;

  assign wake       = new_req || !q_empty;
  assign thr_arr[0] = pd_thresh;
  assign thr_arr[1] = sr_thresh;

  for (genvar g = 0; g < NTIMER; g++) begin : g_timer
    dlp_idle_timer #(.CW(CW)) u_tmr (
      .clk  (clk),
      .rst_n(rst_n),
      .clr  (wake),
      .thr  (thr_arr[g]),
      .hit  (hit_vec[g])
    );
  end

  dlp_fsm #(.WW(WW)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .wake      (wake),
    .pd_hit    (hit_vec[0]),
    .sr_hit    (hit_vec[1]),
    .force_pre (force_pre),
    .row_open  (|bank_open),
    .xwait     (xwait_cycles),
    .dcmd_valid(dcmd_valid),
    .dcmd_code (dcmd_code),
    .cke       (cke),
    .cmd       (cmd),
    .st        (st),
    .pd_act    (pd_active)
  );

  assign clk_en    = !f_clock_stop(clkstop_en, mem_is_lp, st, pd_active);
  assign cmd_code  = cmd;
  assign cmd_valid = (cmd != CMD_NOP);
  assign busy      = (st != ST_RUN);

  // R8: the memory clock is gated only while cke is low
  a_r8_gate_needs_cke_low: assert property (@(posedge clk) disable iff (!rst_n)
    !clk_en |-> !cke);

  // R8: the gate is never closed without permission
  a_r8_gate_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    !clkstop_en |-> clk_en);

endmodule

// File: tb/dram_lowpower_mgr_tb_top.sv
module dram_lowpower_mgr_tb_top;

  localparam int NB = 8;
  localparam int CW = 16;
  localparam int WW = 8;
  localparam int WD = 20000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic q_empty = 1'b0, new_req = 1'b0;
  logic [NB-1:0] bank_open = '0;
  logic [CW-1:0] pd_thresh = '0, sr_thresh = '0;
  logic force_pre = 1'b0, clkstop_en = 1'b0, mem_is_lp = 1'b0;
  logic [WW-1:0] xwait_cycles = '0;
  logic dcmd_valid = 1'b0;
  logic [1:0] dcmd_code = 2'd0;
  logic cke, clk_en, cmd_valid, pd_active, busy;
  logic [2:0] cmd_code;

  always #5 clk = ~clk;

  dram_lowpower_mgr #(.NB(NB), .CW(CW), .WW(WW)) dut_i (
    .clk(clk), .rst_n(rst_n), .q_empty(q_empty), .new_req(new_req),
    .bank_open(bank_open), .pd_thresh(pd_thresh), .sr_thresh(sr_thresh),
    .force_pre(force_pre), .clkstop_en(clkstop_en), .mem_is_lp(mem_is_lp),
    .xwait_cycles(xwait_cycles), .dcmd_valid(dcmd_valid), .dcmd_code(dcmd_code),
    .cke(cke), .clk_en(clk_en), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
    .pd_active(pd_active), .busy(busy)
  );

  int n_cmp = 0, n_bad = 0, cyc = 0;
  string tag = "R11";

  // reference model: mode names as integers
  localparam int M_NORM = 0, M_PD = 1, M_SR = 2, M_DPD = 3, M_HOLD = 4,
                 M_TO_PD = 5, M_TO_SR = 6, M_PD_TO_SR = 7;
  int m_mode = M_NORM, idle_run = 0, hold_left = 0;
  int m_cmd = 0;
  bit m_cke = 1, m_act = 0;

  always @(posedge clk) begin
    bit quiet, pd_due, sr_due;
    if (!rst_n) begin
      m_mode = M_NORM; idle_run = 0; hold_left = 0;
      m_cmd = 0; m_cke = 1; m_act = 0;
    end else begin
      quiet  = q_empty && !new_req;
      pd_due = (pd_thresh != 0) && (idle_run >= int'(pd_thresh));
      sr_due = (sr_thresh != 0) && (idle_run >= int'(sr_thresh));
      m_cmd = 0;
      case (m_mode)
        M_NORM:
          if (dcmd_valid && dcmd_code == 2'd1) begin
            m_cmd = 2; m_cke = 0; m_act = (bank_open != 0); m_mode = M_PD;
          end else if (dcmd_valid && dcmd_code == 2'd2) begin
            m_cmd = 1; m_mode = M_TO_SR;
          end else if (dcmd_valid && dcmd_code == 2'd3) begin
            m_cmd = 6; m_cke = 0; m_mode = M_DPD;
          end else if (quiet && sr_due) begin
            m_cmd = 1; m_mode = M_TO_SR;
          end else if (quiet && pd_due) begin
            if (force_pre) begin m_cmd = 1; m_mode = M_TO_PD; end
            else begin m_cmd = 2; m_cke = 0; m_act = (bank_open != 0); m_mode = M_PD; end
          end
        M_TO_PD: begin m_cmd = 2; m_cke = 0; m_act = 0; m_mode = M_PD; end
        M_PD:
          if (!quiet) begin m_cmd = 3; m_cke = 1; m_act = 0; m_mode = M_NORM; end
          else if (sr_due) begin m_cmd = 3; m_cke = 1; m_act = 0; m_mode = M_PD_TO_SR; end
        M_PD_TO_SR: begin m_cmd = 1; m_mode = M_TO_SR; end
        M_TO_SR: begin m_cmd = 4; m_cke = 0; m_mode = M_SR; end
        M_SR:  if (!quiet) begin m_cmd = 5; m_cke = 1; hold_left = int'(xwait_cycles) + 1; m_mode = M_HOLD; end
        M_DPD: if (!quiet) begin m_cmd = 7; m_cke = 1; hold_left = int'(xwait_cycles) + 1; m_mode = M_HOLD; end
        M_HOLD: begin hold_left--; if (hold_left == 0) m_mode = M_NORM; end
        default: m_mode = M_NORM;
      endcase
      idle_run = quiet ? idle_run + 1 : 0;
    end
  end

  function automatic bit exp_clken();
    if (!clkstop_en) return 1;
    if (m_mode == M_SR || m_mode == M_DPD) return 0;
    if (mem_is_lp && m_mode == M_PD && !m_act) return 0;
    return 1;
  endfunction

  // compare on every falling edge, after reset
  always @(negedge clk) begin
    if (rst_n) begin
      bit e_clk, e_busy;
      e_clk  = exp_clken();
      e_busy = (m_mode != M_NORM);
      n_cmp++;
      if (cke !== m_cke || cmd_code !== 3'(m_cmd) || cmd_valid !== (m_cmd != 0) ||
          busy !== e_busy || clk_en !== e_clk || pd_active !== m_act) begin
        n_bad++;
        $display("FAIL %s t=%0t act cke=%b cmd=%0d v=%b busy=%b clk_en=%b pda=%b exp cke=%b cmd=%0d v=%b busy=%b clk_en=%b pda=%b",
                 tag, $time, cke, cmd_code, cmd_valid, busy, clk_en, pd_active,
                 m_cke, m_cmd, (m_cmd != 0), e_busy, e_clk, m_act);
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == WD) begin
      n_bad++;
      $display("FAIL watchdog act=running exp=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin q_empty = 1; new_req = 0; @(negedge clk); end
  endtask

  task automatic traffic(input int n);
    new_req = 1; q_empty = 0; @(negedge clk);
    new_req = 0;
    for (int i = 1; i < n; i++) @(negedge clk);
  endtask

  task automatic dcmd(input logic [1:0] c);
    dcmd_valid = 1; dcmd_code = c; @(negedge clk);
    dcmd_valid = 0; dcmd_code = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R11: reset values
    n_cmp++;
    if (cke !== 1 || clk_en !== 1 || busy !== 0 || cmd_valid !== 0 || cmd_code !== 0 || pd_active !== 0) begin
      n_bad++;
      $display("FAIL R11 act cke=%b clk_en=%b busy=%b cmd=%0d exp 1 1 0 0", cke, clk_en, busy, cmd_code);
    end
    rst_n = 1;
    traffic(3);

    tag = "R1"; pd_thresh = 4; idle(3); traffic(2); idle(10); traffic(4);
    tag = "R2"; bank_open = 8'h10; idle(9); traffic(4);
    bank_open = 8'h00; idle(9); traffic(4);
    tag = "R3"; force_pre = 1; bank_open = 8'h03; idle(10); traffic(4);
    tag = "R4"; force_pre = 0; idle(8); q_empty = 0; repeat (3) @(negedge clk);
    tag = "R5"; pd_thresh = 0; sr_thresh = 5; xwait_cycles = 3; idle(12); traffic(8);
    tag = "R7"; xwait_cycles = 0; idle(10); traffic(5);
    tag = "R6"; pd_thresh = 3; sr_thresh = 9; xwait_cycles = 2; idle(16); traffic(8);
    tag = "R12"; pd_thresh = 4; sr_thresh = 4; idle(10); traffic(8);
    tag = "R8"; sr_thresh = 0; clkstop_en = 1; mem_is_lp = 1; bank_open = 0; idle(8); traffic(4);
    bank_open = 8'h80; idle(8); traffic(4);
    mem_is_lp = 0; bank_open = 0; idle(8); traffic(4);
    pd_thresh = 0; sr_thresh = 3; idle(8); traffic(8);
    mem_is_lp = 1; idle(8); traffic(8);
    tag = "R10"; sr_thresh = 0; idle(40); traffic(4);
    tag = "R9"; q_empty = 1; bank_open = 8'h01; dcmd(2'd1); idle(4); traffic(4);
    dcmd(2'd2); idle(4); dcmd(2'd3); idle(3); traffic(6);
    dcmd(2'd0); idle(3); traffic(3);
    tag = "R13"; xwait_cycles = 4; q_empty = 1; dcmd(2'd3); idle(5); traffic(10);
    tag = "R9"; q_empty = 1; dcmd(2'd1); dcmd(2'd3); idle(3); traffic(5);
    traffic(5);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule